// File: doc/BRIEF.md
# Latency-Timed Functional Unit Slot

This block models the timing of one floating-point execution unit (adder, multiplier or divider class) inside an in-order pipeline. Issue hands it an opaque result tag and a destination register index. The slot holds the instruction for a fixed number of cycles, then offers it to a single writeback stage that other units share. The arithmetic is not modelled: the tag goes in at issue and comes out at writeback unchanged.

Two build-time parameters set its character. `LATENCY` is the number of cycles an instruction spends in the unit. `PIPELINED` selects between two modes. In the single-occupant mode the unit stays busy until its instruction leaves. In the pipelined mode a new instruction may enter every cycle, and the unit reports busy only while its oldest entry is blocked at writeback. The slot also produces the two signals the issue interlock uses: the unit-busy flag, and a one-cycle request to mark the destination register busy. While a finished instruction waits for writeback, it raises a structural-stall flag.

Top module: `fuSlot`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wbValid`, `unitBusy`, `structStall` and `destBusySet` are 0 and `issueReady` is 1.
- R2: An instruction accepted at a clock edge (`issueValid` and `issueReady` both 1) first shows `wbValid`=1 in the LATENCY-th cycle after that edge, with `wbTag` and `wbDest` equal to its issue tag and destination.
- R3: `destBusySet` is 1 for exactly the one cycle that follows an accepting edge, with `destBusyIdx` equal to the destination just accepted, and is 0 at all other times.
- R4: While `wbValid` is 1 and `wbReady` is 0, `structStall` is 1 and the offered instruction stays in place with `wbTag` and `wbDest` stable. `structStall` is 0 whenever `wbValid` is 0 or `wbReady` is 1.
- R5: With PIPELINED=0, `unitBusy` is 1 from the cycle after acceptance until the cycle in which the instruction leaves. In that leaving cycle (`wbValid` and `wbReady` both 1) it is already 0, so a new instruction may be accepted at the same edge.
- R6: With PIPELINED=1, `unitBusy` is 1 only in cycles where `structStall` is 1, so a new instruction can be accepted in every cycle where writeback is not blocking.
- R7: With PIPELINED=1, a writeback stall freezes every entry in the unit. No instruction is lost, and results leave in the order they were accepted.
- R8: `issueReady` is the inverse of `unitBusy`. While `issueReady` is 0, `issueValid` is ignored: the instruction is not accepted, no `destBusySet` follows, and no result for it ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Issue offers an instruction |
| issueReady | output | 1 | Slot can take an instruction this cycle |
| issueTag | input | TAG_W | Opaque result tag of the offered instruction |
| issueDest | input | REG_W | Destination register index of the offered instruction |
| unitBusy | output | 1 | Unit-busy flag for the issue interlock |
| destBusySet | output | 1 | Request to mark `destBusyIdx` busy |
| destBusyIdx | output | REG_W | Register to mark busy |
| wbValid | output | 1 | A finished instruction is offered to writeback |
| wbReady | input | 1 | Shared writeback stage is free |
| wbTag | output | TAG_W | Tag of the offered instruction |
| wbDest | output | REG_W | Destination of the offered instruction |
| structStall | output | 1 | Finished instruction is waiting for writeback |

## Verification
Assertions check four things on every cycle. A blocked offer holds its tag and destination and stays valid. Every busy-set pulse is traced back to an accepting edge. A rejected issue never produces a busy-set. In the single-occupant mode, a departure with no new entry leaves the output empty, and a result never appears in the cycle right after acceptance. Only the bench scenarios can show the exact arrival cycle of each result, the cycle-accurate occupancy of several entries under random writeback back-pressure, and the order in which results leave. The bench shows these by running both modes side by side against a behavioural queue model.

// File: rtl/fuSlotPkg.sv
package fuSlotPkg;
  // Strobes from the control to the payload storage
  typedef struct packed {
    logic load;   // an instruction is accepted at this edge
    logic shift;  // payload stages move one step
  } fuStrobeT;
endpackage

// File: rtl/fuSlotCtrl.sv
module fuSlotCtrl
  import fuSlotPkg::*;
#(
  parameter int LATENCY   = 4,
  parameter bit PIPELINED = 1'b0
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     issueValid,
  input  logic     wbReady,
  output logic     issueReady,
  output logic     unitBusy,
  output logic     wbValid,
  output logic     structStall,
  output logic     destBusySet,
  output fuStrobeT strobes
);
  logic accept;
  logic shiftS;
  logic freshQ;

  generate
    if (PIPELINED) begin : gPipe
      logic [LATENCY-1:0] stageVld;
      logic headV;
      logic advance;

      assign headV   = stageVld[LATENCY-1];
      assign advance = !(headV && !wbReady);

      if (LATENCY == 1) begin : gOne
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)        stageVld <= '0;
          else if (advance) stageVld <= accept;
        end
      end else begin : gMany
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)        stageVld <= '0;
          else if (advance) stageVld <= {stageVld[LATENCY-2:0], accept};
        end
      end

      assign wbValid     = headV;
      assign structStall = headV && !wbReady;
      assign unitBusy    = structStall;
      assign shiftS      = advance;

      // R6: a busy unit still holds its blocked head on the next cycle
      assert_busy_means_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
        unitBusy |=> wbValid);
    end else begin : gSingle
      localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
      logic             occ;
      logic [CNT_W-1:0] cnt;
      logic             headDone;
      logic             leave;

      assign headDone = occ && (cnt == '0);
      assign leave    = headDone && wbReady;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          occ <= 1'b0;
          cnt <= '0;
        end else if (accept) begin
          occ <= 1'b1;
          cnt <= CNT_W'(LATENCY - 1);
        end else if (leave) begin
          occ <= 1'b0;
        end else if (occ && cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end

      assign wbValid     = headDone;
      assign structStall = headDone && !wbReady;
      assign unitBusy    = occ && !leave;
      assign shiftS      = accept;

      // R5: a departure with no new entry leaves the unit empty
      assert_single_occupant_R5: assert property (@(posedge clk) disable iff (!rstN)
        (wbValid && wbReady && !(issueValid && issueReady)) |=> !wbValid);

      if (LATENCY > 1) begin : gLatChk
        // R2: a freshly accepted instruction is never offered the next cycle
        assert_min_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
          (issueValid && issueReady) |=> !wbValid);
      end
    end
  endgenerate

  assign issueReady = !unitBusy;
  assign accept     = issueValid && issueReady;
  assign strobes    = '{load: accept, shift: shiftS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) freshQ <= 1'b0;
    else       freshQ <= accept;
  end
  assign destBusySet = freshQ;

  // R3: every busy-set pulse comes from an accepting edge
  assert_set_from_issue_R3: assert property (@(posedge clk) disable iff (!rstN)
    destBusySet |-> $past(issueValid && issueReady));

  // R8: a rejected issue produces no busy-set request
  assert_reject_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueReady) |=> !destBusySet);
endmodule

// File: rtl/fuSlotData.sv
module fuSlotData
  import fuSlotPkg::*;
#(
  parameter int LATENCY   = 4,
  parameter bit PIPELINED = 1'b0,
  parameter int TAG_W     = 8,
  parameter int REG_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  fuStrobeT         strobes,
  input  logic [TAG_W-1:0] issueTag,
  input  logic [REG_W-1:0] issueDest,
  output logic [TAG_W-1:0] wbTag,
  output logic [REG_W-1:0] wbDest,
  output logic [REG_W-1:0] destBusyIdx
);
  localparam int DEPTH = PIPELINED ? LATENCY : 1;

  logic [TAG_W-1:0] tagQ  [DEPTH];
  logic [REG_W-1:0] destQ [DEPTH];
  logic [REG_W-1:0] pendDest;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        tagQ[i]  <= '0;
        destQ[i] <= '0;
      end
    end else if (strobes.shift) begin
      tagQ[0]  <= issueTag;
      destQ[0] <= issueDest;
      for (int i = 1; i < DEPTH; i++) begin
        tagQ[i]  <= tagQ[i-1];
        destQ[i] <= destQ[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendDest <= '0;
    else if (strobes.load) pendDest <= issueDest;
  end

  assign wbTag       = tagQ[DEPTH-1];
  assign wbDest      = destQ[DEPTH-1];
  assign destBusyIdx = pendDest;
endmodule

// File: rtl/fuSlot.sv
module fuSlot
  import fuSlotPkg::*;
#(
  parameter int LATENCY   = 4,
  parameter bit PIPELINED = 1'b0,
  parameter int TAG_W     = 8,
  parameter int REG_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  output logic             issueReady,
  input  logic [TAG_W-1:0] issueTag,
  input  logic [REG_W-1:0] issueDest,
  output logic             unitBusy,
  output logic             destBusySet,
  output logic [REG_W-1:0] destBusyIdx,
  output logic             wbValid,
  input  logic             wbReady,
  output logic [TAG_W-1:0] wbTag,
  output logic [REG_W-1:0] wbDest,
  output logic             structStall
);
  fuStrobeT strobes;

  fuSlotCtrl #(.LATENCY(LATENCY), .PIPELINED(PIPELINED)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .wbReady(wbReady),
    .issueReady(issueReady), .unitBusy(unitBusy), .wbValid(wbValid),
    .structStall(structStall), .destBusySet(destBusySet), .strobes(strobes)
  );

  fuSlotData #(.LATENCY(LATENCY), .PIPELINED(PIPELINED), .TAG_W(TAG_W), .REG_W(REG_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .issueTag(issueTag),
    .issueDest(issueDest), .wbTag(wbTag), .wbDest(wbDest), .destBusyIdx(destBusyIdx)
  );

  // R4: a blocked offer stays valid with unchanged payload
  assert_hold_when_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbTag) && $stable(wbDest)));

  // R4: the stall flag implies a waiting offer
  assert_stall_has_offer_R4: assert property (@(posedge clk) disable iff (!rstN)
    structStall |=> wbValid);
endmodule

// File: tb/fuSlot_tb.sv
module fuSlot_tb;
  localparam int PERIOD = 10;
  localparam int LAT    = 3;
  localparam int TW     = 8;
  localparam int RW     = 5;

  typedef struct {
    int tag;
    int dest;
    int age;
  } entT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [TW-1:0] issueTag = '0;
  logic [RW-1:0] issueDest = '0;
  logic wbReady = 1'b0;

  logic rdyA, busyA, setA, wbvA, stallA;
  logic [RW-1:0] idxA, wbdA;
  logic [TW-1:0] wbtA;
  logic rdyB, busyB, setB, wbvB, stallB;
  logic [RW-1:0] idxB, wbdB;
  logic [TW-1:0] wbtB;

  int vectors = 0;
  int misses = 0;
  int nextTag = 1;
  bit done = 1'b0;

  entT qA[$];
  entT qB[$];
  bit freshA = 1'b0, freshB = 1'b0;
  int fDestA = 0, fDestB = 0;

  always #(PERIOD/2) clk = ~clk;

  fuSlot #(.LATENCY(LAT), .PIPELINED(1'b0), .TAG_W(TW), .REG_W(RW)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(rdyA),
    .issueTag(issueTag), .issueDest(issueDest), .unitBusy(busyA),
    .destBusySet(setA), .destBusyIdx(idxA), .wbValid(wbvA), .wbReady(wbReady),
    .wbTag(wbtA), .wbDest(wbdA), .structStall(stallA)
  );

  fuSlot #(.LATENCY(LAT), .PIPELINED(1'b1), .TAG_W(TW), .REG_W(RW)) u_dutPipe (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(rdyB),
    .issueTag(issueTag), .issueDest(issueDest), .unitBusy(busyB),
    .destBusySet(setB), .destBusyIdx(idxB), .wbValid(wbvB), .wbReady(wbReady),
    .wbTag(wbtB), .wbDest(wbdB), .structStall(stallB)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare one slot with its model, then advance the model over the coming edge
  task automatic checkSlot(input bit pipe, ref entT q[$], ref bit fresh, ref int fDest,
                           input logic rdy, input logic busy, input logic setO,
                           input logic [RW-1:0] idx, input logic wbv,
                           input logic [TW-1:0] wbt, input logic [RW-1:0] wbd,
                           input logic stl);
    bit headV, expStall, expBusy, acc;
    string m;
    m = pipe ? "pipe" : "single";
    headV    = (q.size() > 0) && (q[0].age == LAT - 1);
    expStall = headV && !wbReady;
    if (pipe) expBusy = expStall;
    else      expBusy = (q.size() > 0) && !(headV && wbReady);
    acc = issueValid && !expBusy;

    cmp(pipe ? "R2,R7" : "R2", {m, " wbValid"}, int'(wbv), int'(headV));
    if (headV) begin
      cmp(pipe ? "R2,R7" : "R2", {m, " wbTag"}, int'(wbt), q[0].tag);
      cmp("R2", {m, " wbDest"}, int'(wbd), q[0].dest);
    end
    cmp("R4", {m, " structStall"}, int'(stl), int'(expStall));
    cmp(pipe ? "R6" : "R5", {m, " unitBusy"}, int'(busy), int'(expBusy));
    cmp("R8", {m, " issueReady"}, int'(rdy), int'(!expBusy));
    cmp("R3", {m, " destBusySet"}, int'(setO), int'(fresh));
    if (fresh) cmp("R3", {m, " destBusyIdx"}, int'(idx), fDest);

    if (pipe) begin
      if (!expStall) begin
        if (headV) void'(q.pop_front());
        for (int i = 0; i < q.size(); i++) q[i].age++;
      end
    end else begin
      if (headV && wbReady) void'(q.pop_front());
      else if (q.size() > 0 && q[0].age < LAT - 1) q[0].age++;
    end
    if (acc) q.push_back('{tag: int'(issueTag), dest: int'(issueDest), age: 0});
    fresh = acc;
    fDest = int'(issueDest);
  endtask

  task automatic cyc(input bit iv, input bit wbr);
    @(negedge clk);
    issueValid = iv;
    issueTag   = TW'(nextTag);
    issueDest  = RW'(nextTag * 7 + 3);
    wbReady    = wbr;
    nextTag++;
    #1;
    checkSlot(1'b0, qA, freshA, fDestA, rdyA, busyA, setA, idxA, wbvA, wbtA, wbdA, stallA);
    checkSlot(1'b1, qB, freshB, fDestB, rdyB, busyB, setB, idxB, wbvB, wbtB, wbdB, stallB);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    // R1: reset state, while held in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      issueValid = 1'b1;
      wbReady = 1'b1;
      #1;
      cmp("R1", "single wbValid in reset", int'(wbvA), 0);
      cmp("R1", "pipe wbValid in reset", int'(wbvB), 0);
      cmp("R1", "single unitBusy in reset", int'(busyA), 0);
      cmp("R1", "pipe busy-set in reset", int'(setB), 0);
      cmp("R1", "single issueReady in reset", int'(rdyA), 1);
      cmp("R1", "pipe structStall in reset", int'(stallB), 0);
    end
    @(negedge clk);
    issueValid = 1'b0;
    rstN = 1'b1;
    #1;
    cmp("R1", "single busy-set after reset", int'(setA), 0);
    cmp("R1", "pipe issueReady after reset", int'(rdyB), 1);

    // single instruction, writeback always free (R2, R3)
    cyc(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1);

    // issue held high: single-occupant rejects while busy (R8, R5), pipe streams (R6)
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1);

    // writeback blocked while issuing: stall and freeze (R4, R7)
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1);

    // random traffic with back-pressure
    for (int i = 0; i < 400; i++) cyc(1'($urandom % 2), ($urandom % 4) != 0);

    // drain
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1);
    cmp("R7", "pipe entries left after drain", qB.size(), 0);
    cmp("R5", "single entries left after drain", qA.size(), 0);
    cmp("R7", "pipe wbValid after drain", int'(wbvB), 0);

    done = 1'b1;
    summary();
  end
endmodule